// File: doc/BRIEF.md
# Serial DMA Request Pulse Generator

This block turns the buffer status of one full-duplex serial channel into service requests for a DMA controller that works in cycle-steal mode. The transmit side and the receive side each drive their own active-low ready pin. A request is a low pulse of fixed length, started by a rising edge of the matching status: the transmit buffer becoming empty, or a received character becoming available. A status that stays true does not raise a second request.

Each side has its own enable. Edges that arrive while a pulse is already running are counted and issued later, each after at least one high cycle, up to a set limit. When the receive interrupt mode is "first character only" and a special receive condition is flagged, a receive edge raises no DMA pulse. A one-cycle special-condition interrupt request is raised in its place.

Top module: `sio_dma_req`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both ready outputs are high and `sc_irq` is low. The status history resets to "true", so a status input that is already high when reset is released raises no request.
- R2: A request drives its ready pin low for exactly `PULSE_LEN` consecutive cycles. The pin goes low in the cycle after the clock edge that samples the triggering rising edge, or after the edge that starts a held request.
- R3: With `tx_en` high, a low-to-high change of `tx_empty` raises one transmit request. Keeping `tx_empty` high raises no further request.
- R4: With `rx_en` high, a low-to-high change of `rx_avail` raises one receive request on `rx_rdy_n`. This is independent of the transmit side, and both sides may pulse in the same cycles.
- R5: An edge sampled while the side's enable is low is discarded. From the clock edge that samples the enable low, that ready pin is high; a running pulse ends and held requests are dropped.
- R6: An edge that arrives while a pulse is running is held. After the pulse ends, the pin stays high for exactly one cycle and then starts the held pulse. At most `PEND_MAX` requests are held per side, and further edges are dropped.
- R7: When `rx_mode` is 2'b01 (interrupt on first character only) and `rx_special` is high in the cycle of an enabled receive edge, `rx_rdy_n` stays high for that edge. `sc_irq` is then high for exactly the next cycle.
- R8: For `rx_mode` values 2'b00, 2'b10 and 2'b11, `rx_special` has no effect: receive edges raise normal requests and `sc_irq` stays low. `sc_irq` is never raised by the transmit side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit request enable |
| rx_en | input | 1 | Receive request enable |
| tx_empty | input | 1 | Transmit buffer empty status |
| rx_avail | input | 1 | Received character available status |
| rx_mode | input | 2 | Receive interrupt mode; 2'b01 = first character only |
| rx_special | input | 1 | Special receive condition flag |
| tx_rdy_n | output | 1 | Active-low transmit DMA request |
| rx_rdy_n | output | 1 | Active-low receive DMA request |
| sc_irq | output | 1 | Special-condition interrupt request, one cycle |

## Verification
The bench builds the block with `PULSE_LEN` = 3 and `PEND_MAX` = 2. The shallow hold limit lets a short burst of edges during a pulse overflow the pending store within a few cycles, so the drop rule is exercised. The three-cycle pulse leaves room for an enable to be cleared in the first, middle or last low cycle. It also makes the one-cycle gap between back-to-back held pulses easy to observe.

// File: rtl/sio_drq_pkg.sv
package sio_drq_pkg;

  typedef enum logic [1:0] {
    RXI_NONE    = 2'b00,
    RXI_FIRST   = 2'b01,
    RXI_ALL_PAR = 2'b10,
    RXI_ALL     = 2'b11
  } rx_irq_mode_e;

  localparam int LANE_TX   = 0;
  localparam int LANE_RX   = 1;
  localparam int NUM_LANES = 2;

  // a receive edge is diverted to the interrupt path only in first-char mode
  function automatic logic rx_divert(input rx_irq_mode_e mode, input logic special);
    return (mode == RXI_FIRST) && special;
  endfunction

endpackage

// File: rtl/sio_drq_edge.sv
module sio_drq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic rise
);
  logic cond_q;

  // history starts "true" so a condition already set at reset is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b1;
    else        cond_q <= cond;
  end

  assign rise = cond && !cond_q;
endmodule

// File: rtl/sio_drq_pulse.sv
module sio_drq_pulse #(
  parameter int PULSE_LEN = 3,
  parameter int PEND_MAX  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fire,
  output logic rdy_n,
  output logic pend_nz
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam int PW    = $clog2(PEND_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    pend;
  logic             idle;
  logic             start;

  function automatic logic [PW-1:0] sat_inc(input logic [PW-1:0] v);
    return (v == PW'(PEND_MAX)) ? v : v + PW'(1);
  endfunction

  assign idle    = (cnt == '0);
  assign pend_nz = (pend != '0);
  assign start   = idle && (fire || pend_nz);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= '0;
    end else if (!en) begin
      cnt  <= '0;
      pend <= '0;
    end else if (start) begin
      cnt <= CNT_W'(PULSE_LEN);
      // a fresh edge together with a held one: serve the held one, keep the count
      if (!fire) pend <= pend - PW'(1);
    end else if (!idle) begin
      cnt <= cnt - CNT_W'(1);
      if (fire) pend <= sat_inc(pend);
    end
  end

  assign rdy_n = idle;
endmodule

// File: rtl/sio_dma_req.sv
module sio_dma_req
  import sio_drq_pkg::*;
#(
  parameter int PULSE_LEN = 3,
  parameter int PEND_MAX  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       rx_en,
  input  logic       tx_empty,
  input  logic       rx_avail,
  input  logic [1:0] rx_mode,
  input  logic       rx_special,
  output logic       tx_rdy_n,
  output logic       rx_rdy_n,
  output logic       sc_irq
);
  logic [NUM_LANES-1:0] lane_cond;
  logic [NUM_LANES-1:0] lane_en;
  logic [NUM_LANES-1:0] lane_rise;
  logic [NUM_LANES-1:0] lane_fire;
  logic [NUM_LANES-1:0] lane_rdy_n;
  logic [NUM_LANES-1:0] lane_pend;

  // named internal events for the checker
  logic tx_rise, rx_rise, tx_pend_nz, rx_pend_nz;
  logic sc_divert;
  logic sc_req;
  logic sc_q;

  assign lane_cond[LANE_TX] = tx_empty;
  assign lane_cond[LANE_RX] = rx_avail;
  assign lane_en[LANE_TX]   = tx_en;
  assign lane_en[LANE_RX]   = rx_en;

  assign sc_divert = rx_divert(rx_irq_mode_e'(rx_mode), rx_special);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    sio_drq_edge u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .cond (lane_cond[l]),
      .rise (lane_rise[l])
    );

    if (l == LANE_RX) begin : g_rx_gate
      assign lane_fire[l] = lane_en[l] && lane_rise[l] && !sc_divert;
    end else begin : g_tx_gate
      assign lane_fire[l] = lane_en[l] && lane_rise[l];
    end

    sio_drq_pulse #(
      .PULSE_LEN(PULSE_LEN),
      .PEND_MAX (PEND_MAX)
    ) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (lane_en[l]),
      .fire   (lane_fire[l]),
      .rdy_n  (lane_rdy_n[l]),
      .pend_nz(lane_pend[l])
    );
  end

  assign tx_rise    = lane_rise[LANE_TX];
  assign rx_rise    = lane_rise[LANE_RX];
  assign tx_pend_nz = lane_pend[LANE_TX];
  assign rx_pend_nz = lane_pend[LANE_RX];

  assign sc_req = rx_en && rx_rise && sc_divert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sc_q <= 1'b0;
    else        sc_q <= sc_req;
  end

  assign tx_rdy_n = lane_rdy_n[LANE_TX];
  assign rx_rdy_n = lane_rdy_n[LANE_RX];
  assign sc_irq   = sc_q;
endmodule

// File: rtl/sio_dma_req_chk.sv
module sio_dma_req_chk #(
  parameter int PULSE_LEN = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       rx_en,
  input logic [1:0] rx_mode,
  input logic       rx_special,
  input logic       tx_rdy_n,
  input logic       rx_rdy_n,
  input logic       sc_irq,
  input logic       tx_rise,
  input logic       rx_rise,
  input logic       tx_pend_nz,
  input logic       rx_pend_nz
);
  int tx_run, rx_run;
  logic first_mode;

  assign first_mode = (rx_mode == 2'b01) && rx_special;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_run <= 0;
      rx_run <= 0;
    end else begin
      tx_run <= tx_rdy_n ? 0 : tx_run + 1;
      rx_run <= rx_rdy_n ? 0 : rx_run + 1;
    end
  end

  // R2: a pulse that ends on its own has the full length
  a_r2_tx_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_rdy_n) |-> (tx_run == PULSE_LEN || !$past(tx_en)));
  a_r2_rx_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_rdy_n) |-> (rx_run == PULSE_LEN || !$past(rx_en)));

  // R3: enabled transmit edge on an idle side starts a pulse
  a_r3_tx_start: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rise && tx_en && tx_rdy_n && !tx_pend_nz |=> !tx_rdy_n);

  // R4: enabled receive edge, not diverted, starts a pulse
  a_r4_rx_start: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rise && rx_en && rx_rdy_n && !rx_pend_nz && !first_mode |=> !rx_rdy_n);

  // R5: a disabled side is high from the next clock
  a_r5_tx_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx_en) |-> tx_rdy_n);
  a_r5_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_en) |-> rx_rdy_n);

  // R6: a held request starts right after the one-cycle gap
  a_r6_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_rdy_n) && tx_en && tx_pend_nz |=> !tx_rdy_n);

  // R7: diverted receive edge gives the interrupt and no pulse start
  a_r7_sc_raise: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rise && rx_en && first_mode |=> sc_irq);
  a_r7_sc_cause: assert property (@(posedge clk) disable iff (!rst_n)
    sc_irq |-> $past(rx_rise && rx_en && first_mode));
endmodule

bind sio_dma_req sio_dma_req_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (.*);

// File: tb/tb_sio_dma_req.sv
module tb_sio_dma_req;
  localparam int PL = 3;
  localparam int PM = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, rx_en = 1'b0;
  logic tx_empty = 1'b0, rx_avail = 1'b0;
  logic [1:0] rx_mode = 2'b00;
  logic rx_special = 1'b0;
  logic tx_rdy_n, rx_rdy_n, sc_irq;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // behavioural reference state
  int  left_m[2];
  int  held_m[2];
  bit  seen_m[2];
  bit  sc_m;

  always #5 clk = ~clk;

  sio_dma_req #(.PULSE_LEN(PL), .PEND_MAX(PM)) dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .tx_empty(tx_empty), .rx_avail(rx_avail), .rx_mode(rx_mode),
    .rx_special(rx_special), .tx_rdy_n(tx_rdy_n), .rx_rdy_n(rx_rdy_n),
    .sc_irq(sc_irq)
  );

  task automatic model_reset();
    for (int l = 0; l < 2; l++) begin
      left_m[l] = 0;
      held_m[l] = 0;
      seen_m[l] = 1'b1;
    end
    sc_m = 1'b0;
  endtask

  task automatic model_step();
    bit divert;
    bit sc_next;
    divert  = (rx_mode == 2'b01) && rx_special;
    sc_next = 1'b0;
    for (int l = 0; l < 2; l++) begin
      bit c, e, edge_now, go;
      c = (l == 1) ? rx_avail : tx_empty;
      e = (l == 1) ? rx_en : tx_en;
      edge_now = c && !seen_m[l];
      seen_m[l] = c;
      go = e && edge_now && !(l == 1 && divert);
      if (l == 1 && e && edge_now && divert) sc_next = 1'b1;
      if (!e) begin
        left_m[l] = 0;
        held_m[l] = 0;
      end else if (left_m[l] == 0) begin
        if (go) left_m[l] = PL;
        else if (held_m[l] > 0) begin
          left_m[l] = PL;
          held_m[l]--;
        end
      end else begin
        left_m[l]--;
        if (go && held_m[l] < PM) held_m[l]++;
      end
    end
    sc_m = sc_next;
  endtask

  task automatic check1(string name, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", cur_req, name, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rst_n) model_reset();
    else model_step();
    @(negedge clk);
    check1("tx_rdy_n", tx_rdy_n, left_m[0] == 0);
    check1("rx_rdy_n", rx_rdy_n, left_m[1] == 0);
    check1("sc_irq",   sc_irq,   sc_m);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    // R1: reset state, status already high at release
    cur_req = "R1";
    tx_empty = 1'b1; rx_avail = 1'b1; tx_en = 1'b1; rx_en = 1'b1;
    ticks(3);
    @(negedge clk);
    rst_n = 1'b1;
    ticks(6);

    // R3: transmit edge, then held high
    cur_req = "R3";
    tx_empty = 1'b0; ticks(2);
    tx_empty = 1'b1; ticks(10);

    // R2: pulse length seen alone on the receive side
    cur_req = "R2";
    rx_avail = 1'b0; ticks(2);
    rx_avail = 1'b1; ticks(6);

    // R4: both sides together
    cur_req = "R4";
    tx_empty = 1'b0; rx_avail = 1'b0; ticks(2);
    tx_empty = 1'b1; rx_avail = 1'b1; ticks(8);

    // R6: a burst of edges overflows the hold store
    cur_req = "R6";
    for (int k = 0; k < 8; k++) begin
      tx_empty = 1'b0; tick();
      tx_empty = 1'b1; tick();
    end
    ticks(25);

    // R5: enable cleared mid pulse, edges while disabled
    cur_req = "R5";
    tx_empty = 1'b0; tick();
    tx_empty = 1'b1; ticks(2);
    tx_en = 1'b0; ticks(3);
    tx_empty = 1'b0; tick();
    tx_empty = 1'b1; ticks(4);
    tx_en = 1'b1; ticks(4);
    rx_avail = 1'b0; tick();
    rx_avail = 1'b1; tick();
    rx_avail = 1'b0; tick();
    rx_avail = 1'b1; tick();
    rx_en = 1'b0; ticks(4);
    rx_en = 1'b1; ticks(8);

    // R7: first-character mode diverts to the interrupt
    cur_req = "R7";
    rx_mode = 2'b01; rx_special = 1'b1;
    rx_avail = 1'b0; tick();
    rx_avail = 1'b1; ticks(6);
    rx_special = 1'b0;
    rx_avail = 1'b0; tick();
    rx_avail = 1'b1; ticks(6);

    // R8: other modes ignore the special flag
    cur_req = "R8";
    rx_special = 1'b1;
    for (int m = 0; m < 4; m++) begin
      if (m != 1) begin
        rx_mode = 2'(m);
        rx_avail = 1'b0; tick();
        rx_avail = 1'b1; ticks(6);
      end
    end

    // R2: mixed stimulus against the reference
    cur_req = "R2";
    for (int i = 0; i < 400; i++) begin
      tx_empty   = 1'($urandom_range(0, 1));
      rx_avail   = 1'($urandom_range(0, 1));
      rx_special = ($urandom_range(0, 3) == 0);
      rx_mode    = 2'($urandom_range(0, 3));
      tx_en      = ($urandom_range(0, 9) != 0);
      rx_en      = ($urandom_range(0, 9) != 0);
      tick();
    end
    ticks(10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule